// File: doc/BRIEF.md
# Host register interface with interrupt

This block is the processor-facing slave port of a SCSI protocol controller. A host selects it with an active-low chip select and then reads or writes one of sixteen byte locations through a 4-bit address, separate active-low read and write strobes and a bidirectional 8-bit data bus. The data bus carries a ninth odd-parity line.

Reads are combinational. The block drives the addressed byte and its parity while chip select and read strobe are both low, and it leaves the bus floating at all other times. Writes take effect on the rising edge of the write strobe. The strobes are brought into the system clock domain, and one rising edge is detected per pulse. Data and address are captured while the strobe is still low, so each pulse gives exactly one commit.

Location 0x5 is two registers: reads return a live phase-status input and writes load a diagnostic-control byte. Location 0x4 reads the pending interrupt bits, and a write to it clears the bits written as one. The block also holds a 24-bit transfer count as three read/write bytes, an interrupt mask and an interrupt output. The host stays notified until it clears the condition. The bus-reset source cannot be masked.

Top module: `host_reg_if`

## Requirements
- R1: After reset, the mask, diagnostic, count and pending registers are all zero, `irq` is low and the data bus is not driven.
- R2: The block drives `hd` and `hd_par` only while `cs_n` and `rd_n` are both low. `hd_par` makes the total number of ones across `hd` and `hd_par` odd. At all other times both are high-impedance.
- R3: A write commits once per rising edge of `wr_n`, and only while `cs_n` is low. A strobe pulse with `cs_n` high changes nothing.
- R4: Writes to address 0xF are ignored. Reads of 0xF return the `ext_status` input.
- R5: The transfer count bytes are read/write: most significant at 0xC, middle at 0xD, least significant at 0xE.
- R6: A read of address 0x5 returns `phase_in`. A write to 0x5 loads the diagnostic byte, which appears on `diag_ctl`.
- R7: A read of address 0x4 returns the pending bits. A write to 0x4 clears each pending bit whose data bit is one and leaves the others unchanged.
- R8: A clock cycle with `irq_src[i]` high sets pending bit i. When a set and a clear fall in the same cycle, the set wins.
- R9: Address 0x1 is the read/write interrupt mask. `irq` is high when any pending bit is high and its mask bit is one. Pending bit 7 (bus reset) raises `irq` whatever the mask holds.
- R10: Every other address reads as 0x00 with `hd_par` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; commit on rising edge |
| addr | input | 4 | Register address |
| hd | inout | 8 | Bidirectional data bus |
| hd_par | inout | 1 | Odd parity for hd |
| phase_in | input | 8 | Phase-status byte returned at 0x5 |
| ext_status | input | 8 | Byte returned at 0xF |
| irq_src | input | 8 | Interrupt event inputs; bit 7 is bus reset |
| diag_ctl | output | 8 | Diagnostic-control register |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench goes after the split address first. If a design kept the read and write registers at 0x5 as one, a read there would return the last diagnostic write instead of `phase_in`. It then writes to 0xF and reads it back. A design that did not ignore that write would alias it onto 0xF or onto the neighbouring count byte. Further tests pulse the write strobe with chip select high and pulse a masked source against the bus-reset source. A design that sampled strobes without a select check would corrupt the count, and one that masked every bit alike would leave `irq` low on a bus reset. A clear written while a source is still active must leave that bit pending. A design in which the clear wins would drop a live event.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
   localparam int ADDR_W = 4;
   typedef logic [ADDR_W-1:0] addr_t;

   localparam addr_t A_MASK     = 4'h1;
   localparam addr_t A_INTS     = 4'h4;
   localparam addr_t A_PHASE    = 4'h5;
   localparam addr_t A_CNT_BASE = 4'hC;
   localparam addr_t A_EXT      = 4'hF;
endpackage

// File: rtl/hreg_strobe_sync.sv
module hreg_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic wr_n,
   output logic capture_en,
   output logic wr_commit
);
   if (STAGES < 2) begin : g_bad_stages
      $error("STAGES must be at least 2");
   end

   logic [STAGES-1:0] cs_q;
   logic [STAGES-1:0] wr_q;
   logic              wr_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q    <= '1;
         wr_q    <= '1;
         wr_prev <= 1'b1;
      end else begin
         cs_q    <= {cs_q[STAGES-2:0], cs_n};
         wr_q    <= {wr_q[STAGES-2:0], wr_n};
         wr_prev <= wr_q[STAGES-1];
      end
   end

   assign capture_en = !wr_q[STAGES-1] && !cs_q[STAGES-1];
   assign wr_commit  = !wr_prev && wr_q[STAGES-1] && !cs_q[STAGES-1];

   AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |=> !wr_commit); // R3
   AST_COMMIT_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |-> $past(!wr_q[STAGES-1])); // R3
endmodule

// File: rtl/hreg_irq.sv
module hreg_irq #(
   parameter int NSRC    = 8,
   parameter int RST_BIT = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src,
   input  logic            clr_stb,
   input  logic [NSRC-1:0] clr_bits,
   input  logic [NSRC-1:0] mask,
   output logic [NSRC-1:0] pend,
   output logic            irq
);
   if (RST_BIT >= NSRC) begin : g_bad_rst
      $error("RST_BIT outside source vector");
   end

   localparam logic [NSRC-1:0] FORCE_EN = NSRC'(1) << RST_BIT;

   logic [NSRC-1:0] clr_eff;
   logic [NSRC-1:0] eff_mask;

   assign clr_eff  = clr_stb ? clr_bits : '0;
   assign eff_mask = mask | FORCE_EN;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~clr_eff) | src;
   end

   assign irq = |(pend & eff_mask);

   AST_RST_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(src[RST_BIT]) |-> irq); // R9
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (src != '0) |=> ((pend & $past(src)) == $past(src))); // R8
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_stb && ((clr_bits & ~src) != '0)) |=> ((pend & $past(clr_bits & ~src)) == '0)); // R7
endmodule

// File: rtl/hreg_file.sv
module hreg_file
   import hreg_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int CNT_BYTES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  addr_t             waddr,
   input  logic [DATA_W-1:0] wdata,
   input  addr_t             raddr,
   input  logic [DATA_W-1:0] phase_in,
   input  logic [DATA_W-1:0] ext_status,
   input  logic [DATA_W-1:0] pend,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] diag,
   output logic              clr_stb,
   output logic [DATA_W-1:0] clr_bits
);
   localparam int CNT_W = DATA_W * CNT_BYTES;

   if (int'(A_CNT_BASE) + CNT_BYTES > int'(A_EXT)) begin : g_bad_cnt
      $error("count bytes overlap the external location");
   end

   logic       wr_ok;
   logic [CNT_W-1:0] cnt_flat;

   assign wr_ok    = we && !(&waddr);
   assign clr_stb  = wr_ok && (waddr == A_INTS);
   assign clr_bits = wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask <= '0;
         diag <= '0;
      end else if (wr_ok) begin
         if (waddr == A_MASK)  mask <= wdata;
         if (waddr == A_PHASE) diag <= wdata;
      end
   end

   for (genvar i = 0; i < CNT_BYTES; i++) begin : g_cnt
      localparam addr_t MY_ADDR = A_CNT_BASE + addr_t'(i);
      logic [DATA_W-1:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           byte_q <= '0;
         else if (wr_ok && waddr == MY_ADDR)   byte_q <= wdata;
      end
      assign cnt_flat[CNT_W-1-i*DATA_W -: DATA_W] = byte_q;
   end

   always_comb begin
      rdata = '0;
      if (raddr == A_MASK)  rdata = mask;
      if (raddr == A_INTS)  rdata = pend;
      if (raddr == A_PHASE) rdata = phase_in;
      if (raddr == A_EXT)   rdata = ext_status;
      for (int i = 0; i < CNT_BYTES; i++) begin
         if (raddr == A_CNT_BASE + addr_t'(i))
            rdata = cnt_flat[CNT_W-1-i*DATA_W -: DATA_W];
      end
   end

   AST_EXT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (&waddr)) |=> ($stable(mask) && $stable(diag) && $stable(cnt_flat))); // R4
   AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(cnt_flat)); // R3
endmodule

// File: rtl/host_reg_if.sv
module host_reg_if
   import hreg_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CNT_BYTES   = 3,
   parameter int SYNC_STAGES = 2,
   parameter int RST_BIT     = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [3:0]        addr,
   inout  wire  [DATA_W-1:0] hd,
   inout  wire               hd_par,
   input  logic [DATA_W-1:0] phase_in,
   input  logic [DATA_W-1:0] ext_status,
   input  logic [DATA_W-1:0] irq_src,
   output logic [DATA_W-1:0] diag_ctl,
   output logic              irq
);
   logic              capture_en;
   logic              wr_commit;
   addr_t             cap_addr;
   logic [DATA_W-1:0] cap_data;
   logic [DATA_W-1:0] rdata;
   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] pend;
   logic              clr_stb;
   logic [DATA_W-1:0] clr_bits;
   logic              drive;

   hreg_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
      .capture_en(capture_en), .wr_commit(wr_commit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_addr <= '0;
         cap_data <= '0;
      end else if (capture_en) begin
         cap_addr <= addr;
         cap_data <= hd;
      end
   end

   hreg_file #(.DATA_W(DATA_W), .CNT_BYTES(CNT_BYTES)) u_file (
      .clk(clk), .rst_n(rst_n), .we(wr_commit), .waddr(cap_addr),
      .wdata(cap_data), .raddr(addr), .phase_in(phase_in),
      .ext_status(ext_status), .pend(pend), .rdata(rdata),
      .mask(mask), .diag(diag_ctl), .clr_stb(clr_stb), .clr_bits(clr_bits)
   );

   hreg_irq #(.NSRC(DATA_W), .RST_BIT(RST_BIT)) u_irq (
      .clk(clk), .rst_n(rst_n), .src(irq_src), .clr_stb(clr_stb),
      .clr_bits(clr_bits), .mask(mask), .pend(pend), .irq(irq)
   );

   assign drive  = !cs_n && !rd_n;
   assign hd     = drive ? rdata : {DATA_W{1'bz}};
   assign hd_par = drive ? ~^rdata : 1'bz;

   AST_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      drive |-> (^{hd, hd_par})); // R2
   AST_NO_COMMIT_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |-> $past(!cs_n, SYNC_STAGES)); // R3
endmodule

// File: tb/host_reg_if_tb.sv
module host_reg_if_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [3:0] addr = '0;
   logic [7:0] tb_d = '0;
   logic       tb_oe = 1'b0;
   logic [7:0] phase_in = 8'h3C;
   logic [7:0] ext_status = 8'h81;
   logic [7:0] irq_src = '0;
   logic [7:0] diag_ctl;
   logic       irq;
   wire  [7:0] hd;
   wire        hd_par;
   int         errors = 0;
   int         checks = 0;
   bit         done = 1'b0;

   assign hd = tb_oe ? tb_d : 8'hzz;

   always #5 clk = ~clk;

   host_reg_if u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .hd(hd), .hd_par(hd_par), .phase_in(phase_in),
      .ext_status(ext_status), .irq_src(irq_src), .diag_ctl(diag_ctl), .irq(irq)
   );

   // vector: [20] write, [19:16] address, [15:8] write data, [7:0] expected read
   localparam int NV = 16;
   localparam logic [20:0] VEC [NV] = '{
      {1'b1, 4'hC, 8'h12, 8'h00},
      {1'b1, 4'hD, 8'h34, 8'h00},
      {1'b1, 4'hE, 8'h56, 8'h00},
      {1'b0, 4'hC, 8'h00, 8'h12},   // R5
      {1'b0, 4'hD, 8'h00, 8'h34},
      {1'b0, 4'hE, 8'h00, 8'h56},
      {1'b1, 4'h5, 8'h9A, 8'h00},
      {1'b0, 4'h5, 8'h00, 8'h3C},   // R6
      {1'b1, 4'hF, 8'hFF, 8'h00},
      {1'b0, 4'hF, 8'h00, 8'h81},   // R4
      {1'b0, 4'hE, 8'h00, 8'h56},
      {1'b0, 4'hC, 8'h00, 8'h12},
      {1'b1, 4'h1, 8'h0F, 8'h00},
      {1'b0, 4'h1, 8'h00, 8'h0F},   // R9
      {1'b0, 4'h3, 8'h00, 8'h00},   // R10
      {1'b0, 4'h7, 8'h00, 8'h00}
   };

   function automatic string tag_of(input logic [3:0] a);
      case (a)
         4'hC, 4'hD, 4'hE: return "R5";
         4'h5:             return "R6";
         4'hF:             return "R4";
         4'h1:             return "R9";
         4'h4:             return "R7";
         default:          return "R10";
      endcase
   endfunction

   task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [7:0] d, input bit sel);
      @(negedge clk);
      addr = a; tb_d = d; tb_oe = 1'b1; cs_n = !sel;
      @(negedge clk);
      wr_n = 1'b0;
      repeat (3) @(negedge clk);
      wr_n = 1'b1;
      repeat (5) @(negedge clk);
      cs_n = 1'b1; tb_oe = 1'b0;
      @(negedge clk);
   endtask

   task automatic bus_read(input logic [3:0] a, input logic [7:0] exp, input string req);
      @(negedge clk);
      addr = a; cs_n = 1'b0; rd_n = 1'b0;
      #2;
      check(req, {hd_par, hd}, {~^exp, exp});
      @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b1;
   endtask

   task automatic pulse_src(input logic [7:0] v);
      @(negedge clk);
      irq_src = v;
      @(negedge clk);
      irq_src = '0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1", {1'b0, irq}, 9'h000);
      check("R1", {1'b0, diag_ctl}, 9'h000);
      bus_read(4'hC, 8'h00, "R1");
      bus_read(4'h1, 8'h00, "R1");
      bus_read(4'h4, 8'h00, "R1");

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][20]) bus_write(VEC[i][19:16], VEC[i][15:8], 1'b1);
         else            bus_read(VEC[i][19:16], VEC[i][7:0], tag_of(VEC[i][19:16]));
      end

      // R6: diagnostic register visible on its port
      check("R6", {1'b0, diag_ctl}, {1'b0, 8'h9A});

      // R3: strobe pulse with chip select high is not a write
      bus_write(4'hC, 8'hEE, 1'b0);
      bus_read(4'hC, 8'h12, "R3");

      // R2: bus released while selected without read strobe
      @(negedge clk);
      addr = 4'hD; cs_n = 1'b0; tb_d = 8'hA5; tb_oe = 1'b1;
      #2;
      check("R2", {1'b0, hd}, {1'b0, 8'hA5});
      @(negedge clk);
      cs_n = 1'b1; tb_oe = 1'b0;

      // R8/R9: masked and unmasked sources
      bus_write(4'h1, 8'h01, 1'b1);
      pulse_src(8'h01);
      check("R9", {1'b0, irq}, 9'h001);
      bus_read(4'h4, 8'h01, "R8");
      pulse_src(8'h02);
      bus_read(4'h4, 8'h03, "R8");
      // R7: clear only the bits written as one
      bus_write(4'h4, 8'h01, 1'b1);
      bus_read(4'h4, 8'h02, "R7");
      check("R9", {1'b0, irq}, 9'h000);
      // R9: bus-reset source ignores the mask
      pulse_src(8'h80);
      check("R9", {1'b0, irq}, 9'h001);
      bus_write(4'h4, 8'h82, 1'b1);
      bus_read(4'h4, 8'h00, "R7");
      check("R7", {1'b0, irq}, 9'h000);
      // R8: set wins over a simultaneous clear
      @(negedge clk);
      irq_src = 8'h04;
      bus_write(4'h4, 8'h04, 1'b1);
      irq_src = '0;
      bus_read(4'h4, 8'h04, "R8");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule